// File: doc/BRIEF.md
# Fractal Escape-Time Iteration Core

This block finds the escape-time count of one point c = (cx, cy) of the complex plane. A start pulse captures the point. The block then runs the recurrence z ← z² + c at one full step per clock, in signed Q4.28 fixed point. The starting value of z is c itself, not zero.

The run ends on the first test where the squared magnitude of z is greater than 4, or once the count has reached 255. The block then pulses done and holds the 8-bit count, which a pixel pipeline uses directly as a colour index. Choosing the coordinates, mapping colours and writing memory are left to the surrounding logic.

Top module: `fracEscapeCore`

## Requirements
- R1: While reset is high and in the cycle after it, busy is 0, done is 0 and count is 0. The reset is synchronous and active high.
- R2: A start sampled while busy is 0 captures cx and cy as both the constant c and the initial z. In the following cycle busy is 1 and count is 0.
- R3: Values are signed two's complement Q4.28 (one unit is 2^28). Each product is formed at 64 bits and its bits [59:28] are kept, which floors the result. The doubled cross term keeps bits [58:27]. The new real part is x² − y² + cx and the new imaginary part is 2xy + cy, both wrapping at 32 bits.
- R4: The escape test compares x² + y², taken at full width, against 4.0 with a strict greater-than. A magnitude of exactly 4 does not escape.
- R5: count is incremented only on a test where the point has not escaped. A point with |c|² > 4 finishes with count 0.
- R6: A point that never escapes finishes with count 255, and its run lasts 256 cycles.
- R7: done is high for exactly one cycle, (count + 1) cycles after the start edge. busy is low in that cycle.
- R8: After a run, count holds its final value until the next accepted start.
- R9: A start that arrives while busy is 1 is ignored. The run in progress continues with its own point and count.
- R10: Escape is detected even when the 32-bit terms are far outside ±2, because the test uses the unwrapped sum of squares.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Captures cx and cy and begins a run when idle |
| cx | input | 32 | Real part of c, signed Q4.28 |
| cy | input | 32 | Imaginary part of c, signed Q4.28 |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse at the end of a run |
| count | output | 8 | Iterations taken; holds until the next start |

## Verification
The main function is tried with the following patterns:
- The origin and −2 are points that never leave the set, so they show whether the cap and the 256-cycle run are correct.
- The points (2, 0) and (0, 2) sit exactly on magnitude 4, so they separate a strict comparison from a non-strict one.
- Points with |c| > 2 and extreme 32-bit values separate an immediate escape from a missed one, and show whether the test uses the unwrapped sum.
- Interior and near-boundary points, plus a spread of pseudo-random points, exercise the floor rounding and the doubled cross term over many steps.
- A start issued in the middle of a long run shows whether it is ignored.

// File: rtl/fracPkg.sv
package fracPkg;
  // Strobes from the control unit to the datapath
  typedef struct packed {
    logic load;  // capture c and seed z with it
    logic step;  // apply one z = z^2 + c update
  } fracStrobes_t;
endpackage

// File: rtl/fracDatapath.sv
module fracDatapath
  import fracPkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 28
) (
  input  logic                     clk,
  input  logic                     rst,
  input  fracStrobes_t             strobes,
  input  logic signed [DATA_W-1:0] cx,
  input  logic signed [DATA_W-1:0] cy,
  output logic                     escaped
);
  localparam int PROD_W = 2 * DATA_W;
  localparam int MAG_W  = PROD_W + 1;
  // 4.0 expressed at the product scale (2*FRAC_W fraction bits)
  localparam logic [MAG_W-1:0] ESC_LIMIT = MAG_W'(4) << (2 * FRAC_W);

  logic signed [DATA_W-1:0] xReg, yReg, cxReg, cyReg;
  logic signed [PROD_W-1:0] xExt, yExt, xSq, ySq, xyProd;
  logic signed [DATA_W-1:0] xSqMid, ySqMid, xyTwice;
  logic signed [DATA_W-1:0] xNext, yNext;
  logic        [MAG_W-1:0]  magWide;

  always_comb begin
    xExt    = PROD_W'(xReg);
    yExt    = PROD_W'(yReg);
    xSq     = xExt * xExt;
    ySq     = yExt * yExt;
    xyProd  = xExt * yExt;
    xSqMid  = xSq[FRAC_W+DATA_W-1:FRAC_W];
    ySqMid  = ySq[FRAC_W+DATA_W-1:FRAC_W];
    xyTwice = xyProd[FRAC_W+DATA_W-2:FRAC_W-1];
    xNext   = xSqMid - ySqMid + cxReg;
    yNext   = xyTwice + cyReg;
    // squares are never negative, so the unsigned wide sum cannot wrap
    magWide = {1'b0, xSq} + {1'b0, ySq};
    escaped = magWide > ESC_LIMIT;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      xReg  <= '0;
      yReg  <= '0;
      cxReg <= '0;
      cyReg <= '0;
    end else if (strobes.load) begin
      xReg  <= cx;
      yReg  <= cy;
      cxReg <= cx;
      cyReg <= cy;
    end else if (strobes.step) begin
      xReg  <= xNext;
      yReg  <= yNext;
    end
  end

  // R2: the seed of z is the captured point itself
  assert_seed_is_c_R2: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (xReg == $past(cx)) && (yReg == $past(cy)));

  // R9: c stays fixed for the whole run unless a new load occurs
  assert_c_held_R9: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(cxReg) && $stable(cyReg));

  // R3: z moves only on a step or a load
  assert_z_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (!strobes.load && !strobes.step) |=> $stable(xReg) && $stable(yReg));
endmodule

// File: rtl/fracCtrl.sv
module fracCtrl
  import fracPkg::*;
#(
  parameter int CNT_W    = 8,
  parameter int MAX_ITER = 255
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             escaped,
  output fracStrobes_t     strobes,
  output logic             busy,
  output logic             done,
  output logic [CNT_W-1:0] count
);
  localparam logic [CNT_W-1:0] CNT_CAP = CNT_W'(MAX_ITER);

  typedef enum logic {ST_IDLE, ST_RUN} ctrlState_t;
  ctrlState_t state;
  logic       stopNow;

  always_comb begin
    busy         = (state == ST_RUN);
    stopNow      = escaped || (count == CNT_CAP);
    strobes.load = start && !busy;
    strobes.step = busy && !stopNow;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      count <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (strobes.load) begin
        state <= ST_RUN;
        count <= '0;
      end else if (busy) begin
        if (stopNow) begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end else begin
          count <= count + 1'b1;
        end
      end
    end
  end

  // R7: done is a single-cycle pulse raised while idle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R4: an escape ends the run at the next edge
  assert_escape_stops_R4: assert property (@(posedge clk) disable iff (rst)
    (busy && escaped) |=> (!busy && done));

  // R6: reaching the cap ends the run with the cap value
  assert_cap_stops_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && count == CNT_CAP) |=> (done && count == CNT_CAP));

  // R8: count holds while idle with no start
  assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(count));

  // R9: a start during a run neither restarts nor clears the count
  assert_busy_start_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (count == $past(count)) || (count == $past(count) + 1'b1));
endmodule

// File: rtl/fracEscapeCore.sv
module fracEscapeCore
  import fracPkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int FRAC_W   = 28,
  parameter int CNT_W    = 8,
  parameter int MAX_ITER = 255
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic signed [DATA_W-1:0] cx,
  input  logic signed [DATA_W-1:0] cy,
  output logic                     busy,
  output logic                     done,
  output logic [CNT_W-1:0]         count
);
  fracStrobes_t strobes;
  logic         escaped;

  fracCtrl #(
    .CNT_W   (CNT_W),
    .MAX_ITER(MAX_ITER)
  ) i_ctrl (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .escaped(escaped),
    .strobes(strobes),
    .busy   (busy),
    .done   (done),
    .count  (count)
  );

  fracDatapath #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W)
  ) i_datapath (
    .clk    (clk),
    .rst    (rst),
    .strobes(strobes),
    .cx     (cx),
    .cy     (cy),
    .escaped(escaped)
  );
endmodule

// File: tb/test_fracEscapeCore.sv
module test_fracEscapeCore;
  localparam int ONE = 1 << 28;

  typedef struct {
    int    expCount;
    longint expCyc;
    string tag;
  } expItem_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic signed [31:0] cx = '0, cy = '0;
  logic        busy, done;
  logic [7:0]  count;

  int     testsRun = 0;
  int     testsFailed = 0;
  longint cycCnt = 0;
  expItem_t scoreQ[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cycCnt <= cycCnt + 1;

  fracEscapeCore i_fracEscapeCore (
    .clk(clk), .rst(rst), .start(start), .cx(cx), .cy(cy),
    .busy(busy), .done(done), .count(count)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Reference escape count from the requirement text
  function automatic int refCount(input logic signed [31:0] px, input logic signed [31:0] py);
    logic signed [31:0] zx, zy, nx;
    logic signed [63:0] sx, sy, sxy;
    logic [64:0] mag;
    zx = px; zy = py;
    for (int n = 0; n < 300; n++) begin
      sx  = 64'(zx) * 64'(zx);
      sy  = 64'(zy) * 64'(zy);
      sxy = 64'(zx) * 64'(zy);
      mag = {1'b0, sx} + {1'b0, sy};
      if (mag > (65'd4 << 56) || n == 255) return n;
      nx = 32'(sx >>> 28) - 32'(sy >>> 28) + px;
      zy = 32'(sxy >>> 27) + py;
      zx = nx;
    end
    return -1;
  endfunction

  // Monitor: compares each done against the scoreboard head
  always @(negedge clk) begin
    if (!rst && done) begin
      if (scoreQ.size() == 0) begin
        check(1'b0, "R7 unexpected done", 1, 0);
      end else begin
        expItem_t it;
        it = scoreQ.pop_front();
        check(count == 8'(it.expCount), it.tag, count, it.expCount);
        check(cycCnt == it.expCyc, "R7 done timing", cycCnt, it.expCyc);
        check(!busy, "R7 busy low at done", busy, 0);
      end
    end
  end

  // Driver: pushes the expected result, pulses start, waits, checks hold
  task automatic runPoint(input logic signed [31:0] px, input logic signed [31:0] py,
                          input string tag, input bit interrupt = 1'b0);
    expItem_t it;
    int n;
    n = refCount(px, py);
    @(negedge clk);
    cx = px; cy = py; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    it.expCount = n; it.expCyc = cycCnt + n + 1; it.tag = tag;
    scoreQ.push_back(it);
    check(busy == 1'b1, "R2 busy after start", busy, 1);
    check(count == 8'd0, "R2 count cleared", count, 0);
    if (interrupt) begin
      repeat (10) @(negedge clk);
      cx = 2 * ONE; cy = ONE; start = 1'b1;  // would escape at once
      @(negedge clk);
      start = 1'b0;
    end
    wait (scoreQ.size() == 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done one cycle", done, 0);
    for (int k = 0; k < 3; k++) begin
      check(count == 8'(n), "R8 count held", count, n);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(busy == 0 && done == 0 && count == 0, "R1 reset state", {busy, done, count}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 0 && done == 0 && count == 0, "R1 after reset", {busy, done, count}, 0);

    runPoint(0, 0, "R6 origin capped");
    runPoint(2 * ONE, ONE, "R5 immediate escape");
    runPoint(2 * ONE, 0, "R4 magnitude exactly 4 real");
    runPoint(0, 2 * ONE, "R4 magnitude exactly 4 imag");
    runPoint(-2 * ONE, 0, "R6 minus two capped");
    runPoint(32'sh7FFFFFFF, 32'sh80000000, "R10 extreme corner");
    runPoint(32'sh80000000, 0, "R10 most negative");
    runPoint(ONE / 4 + ONE / 50, 0, "R3 slow escape near cusp");
    runPoint(-(ONE * 3) / 4, ONE / 10, "R3 neck point");
    runPoint(ONE * 3 / 10, ONE / 2, "R3 boundary point");
    runPoint(-ONE / 10, ONE * 9 / 10, "R3 upper bulb");
    runPoint(0, 0, "R9 busy start ignored", 1'b1);
    begin
      logic [31:0] lfsr = 32'hACE1_2357;
      for (int i = 0; i < 16; i++) begin
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
        runPoint($signed(lfsr) >>> 2, $signed({lfsr[15:0], lfsr[31:16]}) >>> 3, "R3 spread point");
      end
    end
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule